// File: doc/BRIEF.md
# USB Endpoint Event Flag and Interrupt Register

This block is one byte-wide status and control register for a small low-speed USB device function. It records three bus events reported by the serial interface engine as sticky flags. The first is the shared endpoint 1/2 transmit completion, when the buffer has gone out and the host has acknowledged it. The second is a valid end-of-packet detection. The third is bus activity seen while the device is suspended.

Software reads the flags over a simple byte bus. It clears a flag by writing a 1 into the write-only clear bit that shares the flag's position. Writing 0 never disturbs a flag.

Two read/write enable bits decide whether the transmit and end-of-packet flags raise the interrupt request. The resume flag drives a separate wake-up output. While the transmit flag stays uncleared, the block asks the engine to answer the next IN transaction on endpoints 1/2 with NAK.

Top module: `usb_irq_reg`

## Requirements
- R1: A synchronous active-high reset clears every flag and enable. After reset, a read returns 0x00, and irq_o, wake_o and nak_in_o are low.
- R2: A one-cycle pulse on tx_ack_evt sets the transmit flag (read bit 7) at that clock edge. nak_in_o is high exactly while that flag is set.
- R3: A pulse on eop_evt sets the end-of-packet flag (read bit 6) at that clock edge.
- R4: line_act sets the resume flag (read bit 5) only in a cycle where suspend is high. With suspend low, line_act is ignored.
- R5: A write to the register address with wdata bit 7, 6 or 5 at 1 clears the transmit, end-of-packet or resume flag respectively. A 0 in those bits leaves the flag unchanged.
- R6: When a flag's set event and its clear write fall in the same cycle, the flag ends up set.
- R7: Write data bit 3 (transmit interrupt enable) and bit 2 (end-of-packet interrupt enable) are stored by every write to the register address and read back in place. Read bits 4, 1 and 0 are always 0.
- R8: A read with bus_rd high at address REG_ADDR (default 0x3A) returns {txf, eopf, resf, 0, txie, eopie, 0, 0} on bus_rdata one clock later. Any other read, or no read, gives 0x00.
- R9: irq_o is registered. It goes high one clock after (transmit flag AND transmit enable) OR (end-of-packet flag AND end-of-packet enable) holds, and low one clock after that term falls. The resume flag never drives irq_o.
- R10: wake_o is high exactly while the resume flag is set.
- R11: Writes to any other address change neither the flags nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (8) | Byte bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Registered read data |
| tx_ack_evt | input | 1 | Endpoint 1/2 transmit done and acknowledged pulse |
| eop_evt | input | 1 | Valid end-of-packet detected pulse |
| line_act | input | 1 | Bus activity seen on the lines |
| suspend | input | 1 | Device suspend control level |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | Resume flag state |
| nak_in_o | output | 1 | NAK the next endpoint 1/2 IN transaction |

## Verification
Two functions can land on the same edge: the engine's event pulse setting a flag, and a software write clearing that same flag. The bench forces this by raising each event input in the very cycle that carries a write with the matching clear bit at 1. It then expects the flag to read back as set, and irq_o, nak_in_o or wake_o to follow. A separate sweep covers every combination of preset flags, clear mask and enable pair, and compares the read-back byte and the interrupt line against values computed arithmetically.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  // flag indices
  localparam int NFLAG  = 3;
  localparam int F_TX   = 0;
  localparam int F_EOP  = 1;
  localparam int F_RES  = 2;

  // enable indices
  localparam int NEN    = 2;
  localparam int E_TX   = 0;
  localparam int E_EOP  = 1;

  // bit position of flag i (and of its clear bit): 7, 6, 5
  function automatic int flag_bit(input int i);
    return 7 - i;
  endfunction

  // bit position of enable e: 3, 2
  function automatic int en_bit(input int e);
    return 3 - e;
  endfunction

endpackage

// File: rtl/usb_irq_flag.sv
module usb_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  // set has priority over clear so no event is lost
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

endmodule

// File: rtl/usb_irq_bus.sv
module usb_irq_bus
  import usb_irq_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h3A
) (
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [NFLAG-1:0] clr_o,
  output logic             en_we_o,
  output logic [NEN-1:0]   en_wdata_o,
  output logic             rd_hit_o
);

  logic hit;
  assign hit      = (bus_addr == REG_ADDR);
  assign en_we_o  = bus_wr && hit;
  assign rd_hit_o = bus_rd && hit;

  for (genvar i = 0; i < NFLAG; i++) begin : g_clr
    assign clr_o[i] = en_we_o && bus_wdata[flag_bit(i)];
  end

  for (genvar e = 0; e < NEN; e++) begin : g_en
    assign en_wdata_o[e] = bus_wdata[en_bit(e)];
  end

endmodule

// File: rtl/usb_irq_reg.sv
module usb_irq_reg
  import usb_irq_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h3A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tx_ack_evt,
  input  logic          eop_evt,
  input  logic          line_act,
  input  logic          suspend,
  output logic          irq_o,
  output logic          wake_o,
  output logic          nak_in_o
);

  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] flag_q;
  logic [NEN-1:0]   en_q;
  logic [NEN-1:0]   en_wdata;
  logic             en_we;
  logic             rd_hit;
  logic [DW-1:0]    rd_val;
  logic             irq_d;

  usb_irq_bus #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) bus_i (
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .clr_o      (clr_v),
    .en_we_o    (en_we),
    .en_wdata_o (en_wdata),
    .rd_hit_o   (rd_hit)
  );

  // event sources; resume is gated by suspend
  assign set_v[F_TX]  = tx_ack_evt;
  assign set_v[F_EOP] = eop_evt;
  assign set_v[F_RES] = line_act && suspend;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    usb_irq_flag flag_i (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (flag_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NFLAG; i++) rd_val[flag_bit(i)] = flag_q[i];
    for (int e = 0; e < NEN; e++)   rd_val[en_bit(e)]   = en_q[e];
  end

  assign irq_d = (flag_q[F_TX] && en_q[E_TX]) || (flag_q[F_EOP] && en_q[E_EOP]);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_hit ? rd_val : '0;
      irq_o     <= irq_d;
    end
  end

  assign nak_in_o = flag_q[F_TX];
  assign wake_o   = flag_q[F_RES];

endmodule

// File: rtl/usb_irq_reg_chk.sv
module usb_irq_reg_chk
  import usb_irq_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h3A
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             tx_ack_evt,
  input logic             eop_evt,
  input logic             line_act,
  input logic             suspend,
  input logic             irq_o,
  input logic             wake_o,
  input logic             nak_in_o,
  input logic [NFLAG-1:0] flag_q,
  input logic [NEN-1:0]   en_q
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !irq_o && !wake_o && !nak_in_o));

  a_r2_tx_sets: assert property (@(posedge clk) disable iff (rst)
    tx_ack_evt |=> nak_in_o);

  a_r3_eop_sets: assert property (@(posedge clk) disable iff (rst)
    eop_evt |=> flag_q[F_EOP]);

  a_r4_resume_gated: assert property (@(posedge clk) disable iff (rst)
    (!wake_o && !(line_act && suspend)) |=> !wake_o);

  a_r5_tx_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_ADDR && bus_wdata[flag_bit(F_TX)] && !tx_ack_evt) |=> !nak_in_o);

  a_r8_foreign_read_zero: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || bus_addr != REG_ADDR) |=> bus_rdata == '0);

  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    ((flag_q[F_TX] && en_q[E_TX]) || (flag_q[F_EOP] && en_q[E_EOP])) |=> irq_o);

  a_r9_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !((flag_q[F_TX] && en_q[E_TX]) || (flag_q[F_EOP] && en_q[E_EOP])) |=> !irq_o);

  a_r11_foreign_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != REG_ADDR) |=> en_q == $past(en_q));

endmodule

bind usb_irq_reg usb_irq_reg_chk #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .tx_ack_evt (tx_ack_evt),
  .eop_evt    (eop_evt),
  .line_act   (line_act),
  .suspend    (suspend),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .nak_in_o   (nak_in_o),
  .flag_q     (flag_q),
  .en_q       (en_q)
);

// File: tb/usb_irq_reg_tb_top.sv
module usb_irq_reg_tb_top;

  localparam logic [7:0] ADDR = 8'h3A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_ack_evt = 1'b0;
  logic       eop_evt = 1'b0;
  logic       line_act = 1'b0;
  logic       suspend = 1'b0;
  logic       irq_o, wake_o, nak_in_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  usb_irq_reg #(.AW(8), .DW(8), .REG_ADDR(ADDR)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_ack_evt(tx_ack_evt),
    .eop_evt(eop_evt), .line_act(line_act), .suspend(suspend),
    .irq_o(irq_o), .wake_o(wake_o), .nak_in_o(nak_in_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    step();
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  // pre bit2 = tx, bit1 = eop, bit0 = resume
  task automatic pulse(input logic [2:0] pre, input logic susp);
    tx_ack_evt = pre[2]; eop_evt = pre[1]; line_act = pre[0]; suspend = susp;
    step();
    tx_ack_evt = 1'b0; eop_evt = 1'b0; line_act = 1'b0; suspend = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] ev;
    step(); step();
    rst = 1'b0;
    // R1 reset state
    rd(ADDR, d);
    check("R1 read", d, 8'h00);
    check("R1 outs", {5'b0, irq_o, wake_o, nak_in_o}, 8'h00);

    // sweep: preset flags x clear mask x enables (R2 R3 R5 R7 R8 R9 R10)
    for (int pre = 0; pre < 8; pre++) begin
      for (int clr = 0; clr < 8; clr++) begin
        for (int en = 0; en < 4; en++) begin
          wr(ADDR, 8'hE0);
          wr(ADDR, 8'(en << 2));
          pulse(3'(pre), 1'b1);
          step();
          check("R9 irq", {7'b0, irq_o},
                {7'b0, (pre[2] & en[1]) | (pre[1] & en[0])});
          check("R2 nak", {7'b0, nak_in_o}, {7'b0, pre[2]});
          check("R10 wake", {7'b0, wake_o}, {7'b0, pre[0]});
          wr(ADDR, 8'((clr << 5) | (en << 2) | 8'h13));
          rd(ADDR, d);
          ev = 8'(((pre & ~clr & 7) << 5) | (en << 2));
          check("R5 R7 R8 readback", d, ev);
        end
      end
    end

    // R4: activity without suspend is ignored
    wr(ADDR, 8'hE0);
    pulse(3'b001, 1'b0);
    rd(ADDR, d);
    check("R4 no resume awake", d, 8'h00);
    check("R4 wake low", {7'b0, wake_o}, 8'h00);
    // suspend alone sets nothing
    pulse(3'b000, 1'b1);
    rd(ADDR, d);
    check("R4 suspend only", d, 8'h00);

    // R6: set and clear in same cycle, each flag
    for (int f = 0; f < 3; f++) begin
      wr(ADDR, 8'hE0);
      bus_addr = ADDR; bus_wdata = 8'hE0; bus_wr = 1'b1;
      tx_ack_evt = (f == 0); eop_evt = (f == 1); line_act = (f == 2); suspend = 1'b1;
      step();
      bus_wr = 1'b0; tx_ack_evt = 1'b0; eop_evt = 1'b0; line_act = 1'b0; suspend = 1'b0;
      rd(ADDR, d);
      check("R6 set wins", d, 8'(8'h80 >> f));
    end

    // R11: foreign write ignored, foreign read returns 0 (R8)
    wr(ADDR, 8'hE0);
    pulse(3'b111, 1'b1);
    wr(ADDR, 8'h0C);
    wr(8'h3B, 8'hE0);
    wr(8'h00, 8'hFF);
    rd(ADDR, d);
    check("R11 foreign write", d, 8'hEC);
    rd(8'h3B, d);
    check("R8 foreign read", d, 8'h00);
    // R9: resume alone does not interrupt
    wr(ADDR, 8'hCC);
    step();
    check("R9 resume no irq", {7'b0, irq_o}, 8'h00);
    check("R10 wake held", {7'b0, wake_o}, 8'h01);
    // R1: reset again mid-state
    rst = 1'b1; step(); rst = 1'b0;
    rd(ADDR, d);
    check("R1 reset again", d, 8'h00);
    check("R1 outs again", {5'b0, irq_o, wake_o, nak_in_o}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule